// File: doc/BRIEF.md
# Presentation Time Stamp Generator

This block builds the 16-bit presentation time stamp that goes into an isochronous packet header. In normal operation it adds a programmable transport delay to the free-running bus cycle timer. The addition is split into two fields. The low delay nibble is added to the top nibble of the cycle offset, and that nibble counts only to 11. The remaining delay bits, plus any carry out of the nibble, are added to the cycle count, and the cycle count wraps at 8000. The stamp is formed from the low four bits of the resulting count, the summed offset nibble, and the unchanged low eight offset bits.

The block can also take the stamp from the application instead. In that mode the application sends a quadlet at the head of each packet, one byte at a time. The first byte carries a sync strobe, and the low half of that quadlet becomes the stamp. Because the quadlet is sent on the bus, the packet grows by one quadlet, and the block reports that growth to the packet assembler. When stamping is disabled, all outputs stay at zero.

Top module: `ts_stamp_gen`

## Requirements
- R1: After reset, and until a clock edge with stamping enabled, `stamp_o`, `stamp_valid_o` and `extra_quad_o` are zero.
- R2: In computed mode, `stamp_o[11:8]` = (`cyc_offset_i[11:8]` + `xport_delay_i[3:0]`) mod 12, for offsets 0..3071.
- R3: In computed mode, the offset-nibble sum divided by 12 gives a carry of 0, 1 or 2. `stamp_o[15:12]` is bits [3:0] of (`cyc_count_i` + `xport_delay_i[11:4]` + carry) mod 8000, for counts 0..7999.
- R4: In computed mode, `stamp_o[7:0]` equals `cyc_offset_i[7:0]`.
- R5: In computed mode, the stamp and `stamp_valid_o`=1 appear one clock edge after the inputs are sampled, and they follow new inputs on every edge.
- R6: While `stamp_en_i` is 0, after the next edge `stamp_o`=0, `stamp_valid_o`=0 and `extra_quad_o`=0.
- R7: In external mode (`ext_stamp_en_i`=1), a byte sampled with `sync_i` and `valid_i` high is byte 0 of a quadlet. The next three bytes sampled with `valid_i` high are bytes 1 to 3, and edges with `valid_i` low are skipped. The quadlet is byte 0 first (most significant). One edge after byte 3, `stamp_o` = {byte 2, byte 3} and `stamp_valid_o`=1.
- R8: In external mode, `stamp_valid_o` is 0 until a full quadlet has been captured. A new sync byte drops it to 0 and restarts capture, including in the middle of a quadlet.
- R9: `extra_quad_o` is 1 one edge after an edge with both `stamp_en_i` and `ext_stamp_en_i` high, and 0 otherwise (one quadlet of length adjustment).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_count_i | input | 13 | Bus cycle count, 0..7999 |
| cyc_offset_i | input | 12 | Cycle offset, 0..3071 |
| xport_delay_i | input | 12 | Transport delay: [3:0] offset nibble, [11:4] count |
| stamp_en_i | input | 1 | Enable stamp generation and insertion |
| ext_stamp_en_i | input | 1 | Take stamp from application quadlet |
| sync_i | input | 1 | Marks first byte of application packet |
| valid_i | input | 1 | Application byte valid |
| data_i | input | 8 | Application byte |
| stamp_o | output | 16 | Presentation time stamp |
| stamp_valid_o | output | 1 | Stamp holds a usable value |
| extra_quad_o | output | 1 | Packet carries one extra quadlet |

## Verification
A computed stamp is due exactly one edge after its inputs are sampled. An external stamp is due one edge after the edge that takes byte 3. The length flag is due one edge after the mode inputs change. The bench drives inputs on the falling edge and reads outputs 1 ns after the next rising edge, so each check sees exactly one register stage. While capture is in progress, it also checks that valid stays low on the edges in between.

// File: rtl/ts_pkg.sv
package ts_pkg;
  parameter int CNT_W    = 13;
  parameter int CNT_MOD  = 8000;
  parameter int OFS_W    = 12;
  parameter int OFS_HI_W = 4;
  parameter int OFS_SPAN = 12;
  parameter int DLY_W    = 12;
  parameter int BYTE_W   = 8;
  parameter int QUAD_B   = 4;
  parameter int STAMP_W  = 16;

  typedef struct packed {
    logic [STAMP_W-OFS_W-1:0]  cnt_lo;
    logic [OFS_HI_W-1:0]       ofs_hi;
    logic [OFS_W-OFS_HI_W-1:0] ofs_lo;
  } stamp_t;
endpackage

// File: rtl/ts_delay_adder.sv
module ts_delay_adder
  import ts_pkg::*;
#(
  parameter int P_CNT_W    = CNT_W,
  parameter int P_CNT_MOD  = CNT_MOD,
  parameter int P_OFS_W    = OFS_W,
  parameter int P_OFS_HI_W = OFS_HI_W,
  parameter int P_OFS_SPAN = OFS_SPAN,
  parameter int P_DLY_W    = DLY_W,
  parameter int P_STAMP_W  = STAMP_W
) (
  input  logic [P_CNT_W-1:0]   cnt_i,
  input  logic [P_OFS_W-1:0]   ofs_i,
  input  logic [P_DLY_W-1:0]   dly_i,
  output logic [P_STAMP_W-1:0] stamp_o
);
  localparam int LO_W      = P_OFS_W - P_OFS_HI_W;
  localparam int SUM_W     = P_OFS_HI_W + 1;
  localparam int MAX_CARRY = (P_OFS_SPAN - 1 + (2**P_OFS_HI_W) - 1) / P_OFS_SPAN;
  localparam int CAR_W     = $clog2(MAX_CARRY + 1);
  localparam int CSUM_W    = P_CNT_W + 1;
  localparam int SCNT_W    = P_STAMP_W - P_OFS_W;

  logic [SUM_W-1:0]  hi_w;
  logic [CAR_W-1:0]  carry;
  logic [CSUM_W-1:0] cnt_w;

  always_comb begin
    hi_w  = SUM_W'(ofs_i[P_OFS_W-1 -: P_OFS_HI_W]) + SUM_W'(dly_i[P_OFS_HI_W-1:0]);
    carry = '0;
    // nibble wraps at the span, not at 2**width
    for (int k = 0; k < MAX_CARRY; k++) begin
      if (hi_w >= SUM_W'(P_OFS_SPAN)) begin
        hi_w  = hi_w - SUM_W'(P_OFS_SPAN);
        carry = carry + CAR_W'(1);
      end
    end
    cnt_w = CSUM_W'(cnt_i) + CSUM_W'(dly_i[P_DLY_W-1:P_OFS_HI_W]) + CSUM_W'(carry);
    if (cnt_w >= CSUM_W'(P_CNT_MOD)) cnt_w = cnt_w - CSUM_W'(P_CNT_MOD);
    stamp_o = {cnt_w[SCNT_W-1:0], hi_w[P_OFS_HI_W-1:0], ofs_i[LO_W-1:0]};
  end
endmodule

// File: rtl/ts_ext_capture.sv
module ts_ext_capture
  import ts_pkg::*;
#(
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_QUAD_B = QUAD_B
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         arm_i,
  input  logic                         sync_i,
  input  logic                         valid_i,
  input  logic [P_BYTE_W-1:0]          data_i,
  output logic                         done_o,
  output logic [P_QUAD_B*P_BYTE_W-1:0] quad_o
);
  localparam int IDX_W = $clog2(P_QUAD_B);
  localparam int SH_W  = (P_QUAD_B - 1) * P_BYTE_W;

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [SH_W-1:0]  sh_q;
  logic             last_byte;

  assign last_byte = busy_q && (idx_q == IDX_W'(P_QUAD_B - 1));
  assign done_o    = arm_i && valid_i && !sync_i && last_byte;
  assign quad_o    = {sh_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (!arm_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (valid_i && sync_i) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_W'(1);
      sh_q   <= {sh_q[SH_W-P_BYTE_W-1:0], data_i};
    end else if (valid_i && busy_q) begin
      sh_q <= {sh_q[SH_W-P_BYTE_W-1:0], data_i};
      if (last_byte) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ts_stamp_gen.sv
module ts_stamp_gen
  import ts_pkg::*;
#(
  parameter int P_CNT_W    = CNT_W,
  parameter int P_CNT_MOD  = CNT_MOD,
  parameter int P_OFS_W    = OFS_W,
  parameter int P_OFS_HI_W = OFS_HI_W,
  parameter int P_OFS_SPAN = OFS_SPAN,
  parameter int P_DLY_W    = DLY_W,
  parameter int P_BYTE_W   = BYTE_W,
  parameter int P_QUAD_B   = QUAD_B,
  parameter int P_STAMP_W  = STAMP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [P_CNT_W-1:0]   cyc_count_i,
  input  logic [P_OFS_W-1:0]   cyc_offset_i,
  input  logic [P_DLY_W-1:0]   xport_delay_i,
  input  logic                 stamp_en_i,
  input  logic                 ext_stamp_en_i,
  input  logic                 sync_i,
  input  logic                 valid_i,
  input  logic [P_BYTE_W-1:0]  data_i,
  output logic [P_STAMP_W-1:0] stamp_o,
  output logic                 stamp_valid_o,
  output logic                 extra_quad_o
);
  localparam int QUAD_W = P_QUAD_B * P_BYTE_W;

  logic [P_STAMP_W-1:0] calc_stamp;
  logic [QUAD_W-1:0]    ext_quad;
  logic                 ext_done;
  logic                 ext_arm;
  logic [P_STAMP_W-1:0] stamp_q;
  logic                 valid_q;
  logic                 have_q;
  logic                 extra_q;

  assign ext_arm = stamp_en_i && ext_stamp_en_i;

  ts_delay_adder #(
    .P_CNT_W(P_CNT_W), .P_CNT_MOD(P_CNT_MOD), .P_OFS_W(P_OFS_W),
    .P_OFS_HI_W(P_OFS_HI_W), .P_OFS_SPAN(P_OFS_SPAN), .P_DLY_W(P_DLY_W),
    .P_STAMP_W(P_STAMP_W)
  ) u_add (
    .cnt_i  (cyc_count_i),
    .ofs_i  (cyc_offset_i),
    .dly_i  (xport_delay_i),
    .stamp_o(calc_stamp)
  );

  ts_ext_capture #(.P_BYTE_W(P_BYTE_W), .P_QUAD_B(P_QUAD_B)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (ext_arm),
    .sync_i (sync_i),
    .valid_i(valid_i),
    .data_i (data_i),
    .done_o (ext_done),
    .quad_o (ext_quad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      valid_q <= 1'b0;
      have_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      extra_q <= ext_arm;
      if (!stamp_en_i) begin
        stamp_q <= '0;
        valid_q <= 1'b0;
        have_q  <= 1'b0;
      end else if (!ext_stamp_en_i) begin
        stamp_q <= calc_stamp;
        valid_q <= 1'b1;
        have_q  <= 1'b0;
      end else if (ext_done) begin
        stamp_q <= ext_quad[P_STAMP_W-1:0];
        valid_q <= 1'b1;
        have_q  <= 1'b1;
      end else if (valid_i && sync_i) begin
        valid_q <= 1'b0;
        have_q  <= 1'b0;
      end else begin
        valid_q <= have_q;
      end
    end
  end

  assign stamp_o       = stamp_q;
  assign stamp_valid_o = valid_q;
  assign extra_quad_o  = extra_q;
endmodule

// File: rtl/ts_stamp_gen_chk.sv
module ts_stamp_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] cyc_offset_i,
  input logic        stamp_en_i,
  input logic        ext_stamp_en_i,
  input logic        sync_i,
  input logic        valid_i,
  input logic [15:0] stamp_o,
  input logic        stamp_valid_o,
  input logic        extra_quad_o
);
  p_ofs_lo_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stamp_en_i && !ext_stamp_en_i) |=> (stamp_o[7:0] == $past(cyc_offset_i[7:0])));

  p_ofs_hi_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stamp_en_i && !ext_stamp_en_i && cyc_offset_i < 12'd3072) |=> (stamp_o[11:8] < 4'd12));

  p_calc_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stamp_en_i && !ext_stamp_en_i) |=> stamp_valid_o);

  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stamp_en_i |=> (stamp_o == 16'd0 && !stamp_valid_o && !extra_quad_o));

  p_extra_quad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (extra_quad_o == $past(stamp_en_i && ext_stamp_en_i)));

  p_sync_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stamp_en_i && ext_stamp_en_i && sync_i && valid_i) |=> !stamp_valid_o);
endmodule

bind ts_stamp_gen ts_stamp_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cyc_offset_i  (cyc_offset_i),
  .stamp_en_i    (stamp_en_i),
  .ext_stamp_en_i(ext_stamp_en_i),
  .sync_i        (sync_i),
  .valid_i       (valid_i),
  .stamp_o       (stamp_o),
  .stamp_valid_o (stamp_valid_o),
  .extra_quad_o  (extra_quad_o)
);

// File: tb/ts_stamp_gen_tb.sv
`timescale 1ns/100ps
module ts_stamp_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] cyc_count_i = '0;
  logic [11:0] cyc_offset_i = '0;
  logic [11:0] xport_delay_i = '0;
  logic        stamp_en_i = 1'b0;
  logic        ext_stamp_en_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [15:0] stamp_o;
  logic        stamp_valid_o;
  logic        extra_quad_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  ts_stamp_gen u_dut (.*);

  // reference: whole delay in offset-nibble units, wrapped over the full timer span
  function automatic logic [15:0] ref_stamp(int cnt, int ofs, int dly);
    int t, c, h;
    t = (cnt * 12 + (ofs / 256)) + ((dly / 16) * 12 + (dly % 16));
    t = t % (8000 * 12);
    c = t / 12;
    h = t % 12;
    return 16'(((c % 16) << 12) | (h << 8) | (ofs % 256));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic calc_vec(string req, int cnt, int ofs, int dly);
    @(negedge clk_i);
    stamp_en_i = 1'b1; ext_stamp_en_i = 1'b0;
    cyc_count_i = 13'(cnt); cyc_offset_i = 12'(ofs); xport_delay_i = 12'(dly);
    @(posedge clk_i); #1;
    chk(req, {16'd0, stamp_o}, {16'd0, ref_stamp(cnt, ofs, dly)});
    chk("R5 valid", {31'd0, stamp_valid_o}, 32'd1);
  endtask

  task automatic put_byte(logic s, logic v, logic [7:0] d);
    @(negedge clk_i);
    sync_i = s; valid_i = v; data_i = d;
    @(posedge clk_i); #1;
  endtask

  initial begin
    #(200_000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    #1;
    chk("R1 stamp", {16'd0, stamp_o}, 32'd0);
    chk("R1 valid", {31'd0, stamp_valid_o}, 32'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", {14'd0, stamp_o, stamp_valid_o, extra_quad_o}, 32'd0);

    // directed corners
    calc_vec("R2 zero", 0, 0, 0);
    calc_vec("R2 R3 carry two", 100, 11 * 256 + 5, 15);
    calc_vec("R3 count wrap", 7999, 11 * 256 + 255, 255 * 16 + 15);
    calc_vec("R3 single carry", 7990, 6 * 256, 16 * 9 + 6);
    calc_vec("R4 low bits", 1234, 3 * 256 + 171, 16 * 2 + 1);
    chk("R9 computed mode", {31'd0, extra_quad_o}, 32'd0);

    for (int i = 0; i < 400; i++)
      calc_vec("R2 R3 R4 random", int'($urandom % 8000), int'($urandom % 3072),
               int'($urandom % 4096));

    // disable
    @(negedge clk_i); stamp_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R6 off", {14'd0, stamp_o, stamp_valid_o, extra_quad_o}, 32'd0);

    // external stamp
    @(negedge clk_i); stamp_en_i = 1'b1; ext_stamp_en_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R9 ext", {31'd0, extra_quad_o}, 32'd1);
    chk("R8 no quad yet", {31'd0, stamp_valid_o}, 32'd0);
    put_byte(1, 1, 8'hA1);
    put_byte(0, 1, 8'hB2);
    put_byte(0, 0, 8'hEE);
    put_byte(0, 1, 8'hC3);
    chk("R8 partial", {31'd0, stamp_valid_o}, 32'd0);
    put_byte(0, 1, 8'hD4);
    chk("R7 stamp", {16'd0, stamp_o}, 32'h0000C3D4);
    chk("R7 valid", {31'd0, stamp_valid_o}, 32'd1);
    put_byte(0, 0, 8'h00);
    chk("R7 hold", {15'd0, stamp_o, stamp_valid_o}, {15'd0, 16'hC3D4, 1'b1});
    put_byte(1, 1, 8'h11);
    chk("R8 resync", {31'd0, stamp_valid_o}, 32'd0);
    put_byte(0, 1, 8'h22);
    put_byte(1, 1, 8'h33);
    put_byte(0, 1, 8'h44);
    put_byte(0, 1, 8'h55);
    chk("R8 restart mid", {31'd0, stamp_valid_o}, 32'd0);
    put_byte(0, 1, 8'h66);
    chk("R7 restarted stamp", {15'd0, stamp_o, stamp_valid_o}, {15'd0, 16'h5566, 1'b1});

    for (int j = 0; j < 20; j++) begin
      logic [7:0] b [4];
      for (int k = 0; k < 4; k++) b[k] = 8'($urandom);
      put_byte(1, 1, b[0]);
      for (int k = 1; k < 4; k++) begin
        if ($urandom % 2 == 0) put_byte(0, 0, 8'hFF);
        put_byte(0, 1, b[k]);
      end
      chk("R7 random quad", {15'd0, stamp_o, stamp_valid_o}, {15'd0, b[2], b[3], 1'b1});
    end
    put_byte(0, 0, 8'h00);

    @(negedge clk_i); stamp_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R6 R9 off again", {14'd0, stamp_o, stamp_valid_o, extra_quad_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule